// File: doc/BRIEF.md
# Transport Overhead Byte Substitution Multiplexer

This block sits on a byte-wide STS-1 terminal stream and decides, byte by byte, what the outgoing stream carries in the 27 transport overhead positions. Overhead occupies the first three columns of each of the nine rows. For every overhead position, the outgoing byte is one of three things: the byte that arrived, a substitute held in an insert location, or zero. A processor loads the substitutes and a set of thirteen group enables through a small synchronous write port.

Framing substitutes are constants that the block regenerates itself. The two parity substitutes come live from a neighbouring parity generator. All other substitutes are processor-written registers. Substitution applies only in pass-through mode. Under retiming, SPE-only or the reserved mode value, every overhead position leaves as zero.

Payload bytes are never altered, and the latency is fixed. Substituted pointer bytes therefore cannot shift where the payload (and its first byte) appears on the output. New enables and a new mode are adopted only at a frame start, so each frame carries one consistent overhead setting.

Top module: `oh_insert_mux`

## Requirements
- R1: A valid byte with `din_fs` high is row 0, column 0; each further valid byte advances the column from 0 to 89, then wraps to the next row (rows 0 to 8, then back to 0). Each input cycle appears one cycle later on `dout_vld`/`dout_fs` (`dout_fs` = `din_vld & din_fs`), and `dout` is zero in cycles where `din_vld` was low.
- R2: Bytes in columns 3 to 89 are output unchanged in every mode and every control setting.
- R3: In pass-through mode (`mode` = 2'b00), an overhead byte whose group enable is clear is output unchanged.
- R4: In pass-through mode, an overhead byte whose group enable is set is replaced by the insert location with slot index row*3+column. That location is written at address equal to the slot index. Group enable bits: 0 framing (slots 0,1), 1 C1 (2), 2 B1 (3), 3 E1 (4), 4 F1 (5), 5 section DCC (6-8), 6 pointer (9-11), 7 B2 (12), 8 APS (13,14), 9 line DCC (15-23), 10 Z1 (24), 11 Z2 (25), 12 E2 (26).
- R5: The substitutes for slots 0 and 1 are the regenerated framing values 8'hF6 and 8'h28. Writes to addresses 0 and 1 have no effect.
- R6: The substitutes for slots 3 and 12 are `b1_calc` and `b2_calc`, taken in the cycle the byte arrives. Writes to addresses 3 and 12 have no effect.
- R7: When the adopted mode is 2'b01 (retiming), 2'b10 (SPE-only) or 2'b11, every overhead byte is output as 8'h00, whatever the enables are.
- R8: Address 28 sets enable bits 7:0 from `wr_data[7:0]`, and address 29 sets bits 12:8 from `wr_data[4:0]`. The enables and `mode` are adopted at the next valid frame-start byte and apply to that byte and all later bytes of its frame. Writes to addresses 27, 30 and 31 have no effect.
- R9: After reset, `dout`, `dout_vld` and `dout_fs` are 0, all enables and writable insert locations are 0, and the adopted mode is pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 8 | Incoming terminal byte |
| din_vld | input | 1 | `din` holds a byte this cycle |
| din_fs | input | 1 | Byte is row 0, column 0 of a frame |
| mode | input | 2 | 00 pass-through, 01 retiming, 10 SPE-only, 11 reserved |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | 0-26 insert slot, 28/29 enable bits |
| wr_data | input | 8 | Write data |
| b1_calc | input | 8 | Recalculated section parity byte |
| b2_calc | input | 8 | Recalculated line parity byte |
| dout | output | 8 | Outgoing terminal byte |
| dout_vld | output | 1 | `dout` holds a byte |
| dout_fs | output | 1 | Outgoing byte is a frame start |

## Verification
Every result is due exactly one clock after the input cycle that causes it, because the byte selection goes through a single output register. The bench drives a cycle on a falling edge and predicts the output from its model state before that cycle. It then advances the model and compares all three outputs at the following falling edge. A write or mode change takes effect on the output only after a later frame-start byte, one cycle after that byte enters. Mid-frame writes are therefore checked against the old setting for the rest of their frame.

// File: rtl/oh_ins_pkg.sv
package oh_ins_pkg;

   typedef enum logic [1:0] {
      MODE_PASS   = 2'b00,
      MODE_RETIME = 2'b01,
      MODE_SPE    = 2'b10,
      MODE_RSVD   = 2'b11
   } oh_mode_e;

   localparam int OH_ROWS   = 9;
   localparam int OH_COLS   = 3;
   localparam int OH_SLOTS  = OH_ROWS * OH_COLS;
   localparam int OH_GROUPS = 13;
   localparam int SLOT_W    = 5;
   localparam int GRP_W     = 4;

   localparam logic [SLOT_W-1:0] CTRL_LO_ADDR = 5'd28;
   localparam logic [SLOT_W-1:0] CTRL_HI_ADDR = 5'd29;

   localparam int SLOT_A1 = 0;
   localparam int SLOT_A2 = 1;
   localparam int SLOT_B1 = 3;
   localparam int SLOT_B2 = 12;

   // overhead slot (row*3+col) to its enable group
   function automatic logic [GRP_W-1:0] slot_group(input logic [SLOT_W-1:0] s);
      logic [GRP_W-1:0] g;
      case (s)
         5'd0, 5'd1:                     g = 4'd0;
         5'd2:                           g = 4'd1;
         5'd3:                           g = 4'd2;
         5'd4:                           g = 4'd3;
         5'd5:                           g = 4'd4;
         5'd6, 5'd7, 5'd8:               g = 4'd5;
         5'd9, 5'd10, 5'd11:             g = 4'd6;
         5'd12:                          g = 4'd7;
         5'd13, 5'd14:                   g = 4'd8;
         5'd24:                          g = 4'd10;
         5'd25:                          g = 4'd11;
         5'd26:                          g = 4'd12;
         default:                        g = (s >= 5'd15 && s <= 5'd23) ? 4'd9 : 4'd0;
      endcase
      return g;
   endfunction

endpackage

// File: rtl/oh_pos_tracker.sv
module oh_pos_tracker
   import oh_ins_pkg::*;
#(
   parameter int ROWS = 9,
   parameter int COLS = 90
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld,
   input  logic              fs,
   output logic              is_oh,
   output logic [SLOT_W-1:0] slot
);
   localparam int RW = $clog2(ROWS);
   localparam int CW = $clog2(COLS);

   logic [RW-1:0] nxt_row, cur_row;
   logic [CW-1:0] nxt_col, cur_col;

   always_comb begin
      cur_row = fs ? '0 : nxt_row;
      cur_col = fs ? '0 : nxt_col;
      is_oh   = (32'(cur_col) < OH_COLS);
      slot    = SLOT_W'(32'(cur_row) * OH_COLS + 32'(cur_col));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nxt_row <= '0;
         nxt_col <= '0;
      end else if (vld) begin
         if (cur_col == CW'(COLS - 1)) begin
            nxt_col <= '0;
            nxt_row <= (cur_row == RW'(ROWS - 1)) ? '0 : cur_row + 1'b1;
         end else begin
            nxt_col <= cur_col + 1'b1;
            nxt_row <= cur_row;
         end
      end
   end

   AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      32'(nxt_col) < COLS && 32'(nxt_row) < ROWS);   // R1

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !vld |=> $stable(nxt_col) && $stable(nxt_row));   // R1

endmodule

// File: rtl/oh_insert_store.sv
module oh_insert_store
   import oh_ins_pkg::*;
#(
   parameter int              DATA_W = 8,
   parameter int              ADDR_W = 5,
   parameter logic [DATA_W-1:0] A1_PAT = 8'hF6,
   parameter logic [DATA_W-1:0] A2_PAT = 8'h28
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic [DATA_W-1:0]    b1_calc,
   input  logic [DATA_W-1:0]    b2_calc,
   input  logic                 frame_start,
   input  oh_mode_e             mode_in,
   input  logic [SLOT_W-1:0]    slot,
   output logic [DATA_W-1:0]    ins_byte,
   output logic [OH_GROUPS-1:0] cur_ctrl,
   output oh_mode_e             cur_mode
);
   localparam int HI_BITS = OH_GROUPS - 8;

   logic [DATA_W-1:0]    slot_val [OH_SLOTS];
   logic [OH_GROUPS-1:0] shadow_ctrl, act_ctrl;
   oh_mode_e             act_mode;

   for (genvar s = 0; s < OH_SLOTS; s++) begin : g_slot
      if (s == SLOT_A1) begin : g_a1
         assign slot_val[s] = A1_PAT;
      end else if (s == SLOT_A2) begin : g_a2
         assign slot_val[s] = A2_PAT;
      end else if (s == SLOT_B1) begin : g_b1
         assign slot_val[s] = b1_calc;
      end else if (s == SLOT_B2) begin : g_b2
         assign slot_val[s] = b2_calc;
      end else begin : g_reg
         logic [DATA_W-1:0] val_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               val_q <= '0;
            else if (wr_en && wr_addr == ADDR_W'(s))
               val_q <= wr_data;
         end
         assign slot_val[s] = val_q;
      end
   end

   assign ins_byte = (32'(slot) < OH_SLOTS) ? slot_val[slot] : '0;
   assign cur_ctrl = frame_start ? shadow_ctrl : act_ctrl;
   assign cur_mode = frame_start ? mode_in : act_mode;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow_ctrl <= '0;
         act_ctrl    <= '0;
         act_mode    <= MODE_PASS;
      end else begin
         if (frame_start) begin
            act_ctrl <= shadow_ctrl;
            act_mode <= mode_in;
         end
         if (wr_en && wr_addr == ADDR_W'(CTRL_LO_ADDR))
            shadow_ctrl[7:0] <= wr_data[7:0];
         if (wr_en && wr_addr == ADDR_W'(CTRL_HI_ADDR))
            shadow_ctrl[OH_GROUPS-1:8] <= wr_data[HI_BITS-1:0];
      end
   end

   AST_CTRL_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(act_ctrl) && $stable(act_mode));   // R8

   AST_FIXED_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
      slot == 5'd0 |-> ins_byte == A1_PAT);   // R5

endmodule

// File: rtl/oh_insert_mux.sv
module oh_insert_mux
   import oh_ins_pkg::*;
#(
   parameter int                DATA_W = 8,
   parameter int                ADDR_W = 5,
   parameter int                ROWS   = 9,
   parameter int                COLS   = 90,
   parameter logic [DATA_W-1:0] A1_PAT = 8'hF6,
   parameter logic [DATA_W-1:0] A2_PAT = 8'h28
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] din,
   input  logic              din_vld,
   input  logic              din_fs,
   input  logic [1:0]        mode,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] b1_calc,
   input  logic [DATA_W-1:0] b2_calc,
   output logic [DATA_W-1:0] dout,
   output logic              dout_vld,
   output logic              dout_fs
);
   if (DATA_W != 8)         begin : g_chk_w  $error("DATA_W must be 8");          end
   if (ROWS != OH_ROWS)     begin : g_chk_r  $error("ROWS must be 9");            end
   if (COLS <= OH_COLS)     begin : g_chk_c  $error("COLS must exceed 3");        end
   if (ADDR_W < SLOT_W)     begin : g_chk_a  $error("ADDR_W must be at least 5"); end

   logic                 is_oh;
   logic [SLOT_W-1:0]    slot;
   logic [DATA_W-1:0]    ins_byte;
   logic [OH_GROUPS-1:0] cur_ctrl;
   oh_mode_e             cur_mode;
   logic [GRP_W-1:0]     grp;
   logic                 use_ins;
   logic [DATA_W-1:0]    sel;
   logic                 frame_start;

   assign frame_start = din_vld && din_fs;

   oh_pos_tracker #(.ROWS(ROWS), .COLS(COLS)) u_pos (
      .clk   (clk),
      .rst_n (rst_n),
      .vld   (din_vld),
      .fs    (din_fs),
      .is_oh (is_oh),
      .slot  (slot)
   );

   oh_insert_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W),
                     .A1_PAT(A1_PAT), .A2_PAT(A2_PAT)) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .b1_calc     (b1_calc),
      .b2_calc     (b2_calc),
      .frame_start (frame_start),
      .mode_in     (oh_mode_e'(mode)),
      .slot        (slot),
      .ins_byte    (ins_byte),
      .cur_ctrl    (cur_ctrl),
      .cur_mode    (cur_mode)
   );

   always_comb begin
      grp     = slot_group(slot);
      use_ins = cur_ctrl[grp];
      sel     = din;
      if (is_oh) begin
         if (cur_mode != MODE_PASS)
            sel = '0;
         else if (use_ins)
            sel = ins_byte;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dout     <= '0;
         dout_vld <= 1'b0;
         dout_fs  <= 1'b0;
      end else begin
         dout     <= din_vld ? sel : '0;
         dout_vld <= din_vld;
         dout_fs  <= frame_start;
      end
   end

   AST_PAYLOAD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      din_vld && !is_oh |=> dout == $past(din));   // R2

   AST_CLEAR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      din_vld && is_oh && cur_mode == MODE_PASS && !use_ins |=> dout == $past(din));   // R3

   AST_OH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      din_vld && is_oh && cur_mode != MODE_PASS |=> dout == '0);   // R7

   AST_A2_REGEN: assert property (@(posedge clk) disable iff (!rst_n)
      din_vld && is_oh && slot == 5'd1 && cur_mode == MODE_PASS && cur_ctrl[0]
      |=> dout == A2_PAT);   // R5

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !din_vld |=> dout == '0 && !dout_fs && !dout_vld);   // R1

endmodule

// File: tb/sim_oh_insert_mux.sv
module sim_oh_insert_mux;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] din = '0;
   logic       din_vld = 1'b0;
   logic       din_fs = 1'b0;
   logic [1:0] mode = 2'b00;
   logic       wr_en = 1'b0;
   logic [4:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] b1_calc = 8'h00;
   logic [7:0] b2_calc = 8'h00;
   logic [7:0] dout;
   logic       dout_vld;
   logic       dout_fs;

   always #2 clk = ~clk;

   oh_insert_mux u0 (
      .clk(clk), .rst_n(rst_n), .din(din), .din_vld(din_vld), .din_fs(din_fs),
      .mode(mode), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .b1_calc(b1_calc), .b2_calc(b2_calc),
      .dout(dout), .dout_vld(dout_vld), .dout_fs(dout_fs)
   );

   int    n_run = 0;
   int    n_fail = 0;
   bit    done = 0;
   string phase = "";

   // reference model state
   int         m_row = 0, m_col = 0;
   logic [12:0] m_sh = '0, m_act = '0;
   logic [1:0] m_amode = 2'b00;
   logic [7:0] m_ins [27];
   logic [4:0] q_a [$];
   logic [7:0] q_d [$];

   function automatic int grp_of(int s);
      if (s < 2)  return 0;
      if (s == 2) return 1;
      if (s == 3) return 2;
      if (s == 4) return 3;
      if (s == 5) return 4;
      if (s < 9)  return 5;
      if (s < 12) return 6;
      if (s == 12) return 7;
      if (s < 15) return 8;
      if (s < 24) return 9;
      if (s == 24) return 10;
      if (s == 25) return 11;
      return 12;
   endfunction

   task automatic check(string tag, string what, logic [7:0] got, logic [7:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s [%s]: got %h expected %h", tag, what, phase, got, exp);
      end
   endtask

   task automatic push_wr(logic [4:0] a, logic [7:0] d);
      q_a.push_back(a);
      q_d.push_back(d);
   endtask

   // one input cycle; called at a falling edge, returns at the next one
   task automatic step(bit v, bit f, logic [7:0] d);
      logic [7:0] e;
      string tg;
      int r, c, s;
      logic [12:0] ct;
      logic [1:0] md;
      bit we = 0;
      logic [4:0] wa = '0;
      logic [7:0] wd = '0;
      if (q_a.size() > 0) begin
         we = 1; wa = q_a.pop_front(); wd = q_d.pop_front();
      end
      din = d; din_vld = v; din_fs = f;
      wr_en = we; wr_addr = wa; wr_data = wd;
      r  = f ? 0 : m_row;
      c  = f ? 0 : m_col;
      ct = f ? m_sh : m_act;
      md = f ? mode : m_amode;
      if (!v) begin
         e = 8'h00; tg = "R1";
      end else if (c >= 3) begin
         e = d; tg = "R2";
      end else begin
         s = r * 3 + c;
         if (md != 2'b00) begin
            e = 8'h00; tg = "R7";
         end else if (!ct[grp_of(s)]) begin
            e = d; tg = "R3";
         end else if (s == 0) begin
            e = 8'hF6; tg = "R5";
         end else if (s == 1) begin
            e = 8'h28; tg = "R5";
         end else if (s == 3) begin
            e = b1_calc; tg = "R6";
         end else if (s == 12) begin
            e = b2_calc; tg = "R6";
         end else begin
            e = m_ins[s]; tg = "R4";
         end
      end
      if (v) begin
         if (c == 89) begin
            m_col = 0;
            m_row = (r == 8) ? 0 : r + 1;
         end else begin
            m_col = c + 1;
            m_row = r;
         end
         if (f) begin
            m_act = m_sh;
            m_amode = mode;
         end
      end
      if (we) begin
         if (wa < 27 && wa != 0 && wa != 1 && wa != 3 && wa != 12) m_ins[wa] = wd;
         else if (wa == 5'd28) m_sh[7:0] = wd;
         else if (wa == 5'd29) m_sh[12:8] = wd[4:0];
      end
      @(negedge clk);
      check("R1", "dout_vld", {7'b0, dout_vld}, {7'b0, v});
      check("R1", "dout_fs", {7'b0, dout_fs}, {7'b0, v & f});
      check(tg, "dout", dout, e);
   endtask

   task automatic frame(int nbytes, int gap, int seed);
      for (int i = 0; i < nbytes; i++) begin
         if (gap > 0 && (i % gap) == gap - 1) step(0, 0, 8'h00);
         step(1, i == 0, 8'((i * 7 + seed * 13 + 1) & 255));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 27; i++) m_ins[i] = 8'h00;
      repeat (3) @(negedge clk);
      phase = "reset";
      check("R9", "dout", dout, 8'h00);
      check("R9", "dout_vld", {7'b0, dout_vld}, 8'h00);
      check("R9", "dout_fs", {7'b0, dout_fs}, 8'h00);
      rst_n = 1'b1;

      phase = "default pass";
      frame(810, 0, 1);                       // R3 R2 with all enables clear

      phase = "R8 mid-frame setup";
      for (int s = 0; s < 27; s++) push_wr(5'(s), 8'(8'h30 + s));
      push_wr(5'd28, 8'hFF);
      push_wr(5'd29, 8'h1F);
      b1_calc = 8'h5A; b2_calc = 8'hA5;
      frame(810, 0, 2);                       // R8: setting not yet in force

      phase = "full substitution";
      push_wr(5'd0, 8'h11); push_wr(5'd1, 8'h22);       // R5 ignored
      push_wr(5'd3, 8'h33); push_wr(5'd12, 8'h44);      // R6 ignored
      push_wr(5'd27, 8'hFF); push_wr(5'd30, 8'h00);     // R8 ignored
      frame(810, 0, 3);                       // R4 R5 R6

      phase = "partial enables with gaps";
      push_wr(5'd28, 8'h55);
      push_wr(5'd29, 8'h0A);
      frame(810, 5, 4);
      b1_calc = 8'hC3; b2_calc = 8'h3C;
      frame(810, 7, 5);

      phase = "R7 retime";
      mode = 2'b01;
      frame(810, 0, 6);
      phase = "R7 spe-only";
      mode = 2'b10;
      frame(810, 3, 7);
      phase = "R7 reserved";
      mode = 2'b11;
      frame(300, 0, 8);

      phase = "R1 resync and back to pass";
      mode = 2'b00;
      push_wr(5'd28, 8'h00);
      push_wr(5'd29, 8'h00);
      frame(150, 0, 9);
      frame(810, 4, 10);

      repeat (2) step(0, 0, 8'h00);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule